// File: doc/BRIEF.md
# Per-Processor Counter and User Timer Bank

This block holds one timer for each of up to sixteen processors, plus a shared mode register that puts each timer in one of two personalities. In counter mode a timer counts ticks up to a programmable limit, wraps to zero, and raises its processor's interrupt. In user mode the same timer becomes a 63-bit count that software can start and stop. Software reads and writes it as an upper and a lower 32-bit word, and this mode never interrupts.

All timers advance on a shared `tick` strobe. Each tick adds one step of weight 2^9 to the visible count value, and only a running timer advances. Software reaches the block through a plain single-cycle register port. `bus_cpu` selects the timer, and `bus_word` selects the word inside it: 0 is limit/upper, 1 is count/lower, 2 is limit-without-restart, 3 is run status, and 4 is the mode register, which ignores `bus_cpu`. Read data is combinational on the cycle `bus_rd` is high. Any read side effect lands at the closing clock edge. There is no back-pressure: every access completes in the cycle it is presented.

Changing a mode bit has defined side effects on that timer. This keeps software from seeing a half-configured timer after the switch.

Top module: `cpu_timer_bank`

## Requirements
- R1: After reset the mode register reads 0, every timer is in counter mode with limit 0, count 0, the reached flag clear and running set, and every irq is low.
- R2: In counter mode, a write to word 0 sets the limit from wdata[30:9], clears the count and lowers irq. Each tick while running adds 1 at bit 9. The tick that would bring the count to the limit (or to 0x7FFFFE00 when the limit is 0) instead wraps the count to 0 and sets reached and irq. Word 1 reads {reached, count[30:9], 9'b0}.
- R3: In counter mode, a read of word 0 returns {1'b0, limit[30:9], 9'b0} and clears both the reached flag and irq.
- R4: In counter mode, a write to word 2 sets the limit from wdata[30:9] without changing the count.
- R5: In counter mode, writes to word 1 and word 3 have no effect. Word 3 reads the running bit in bit 0.
- R6: Word 4 is the mode register: bit i set puts timer i in user mode. Bits at or above NUM_CPUS are held at 0 and read as 0.
- R7: When a mode bit goes 0 to 1, that timer lowers irq, clears running and clears its count.
- R8: When a mode bit goes 1 to 0, that timer sets running, clears its count and resets its limit to 0 (free-running).
- R9: In user mode, word 0 reads {reached, count[62:32]}, and word 1 reads count[31:0] with bits 8:0 reading 0.
- R10: In user mode, a write to word 0 loads count[62:32] from wdata[30:0]. A write to word 1 loads count[31:9] from wdata[31:9]. Either write clears the reached flag.
- R11: In user mode, a write to word 3 starts the timer when wdata[0] is 1 and stops it when it is 0. A stopped timer keeps its count across ticks.
- R12: In user mode, the tick that would bring the count to 0x7FFFFFFFFFFFFE00 wraps it to 0 and sets reached, and irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count strobe, one step per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_cpu | input | 4 | Timer select for words 0..3 |
| bus_word | input | 3 | Word select, 0..4 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | NUM_CPUS | Per-processor interrupt, counter mode only |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together. They also assume that a timer access names a `bus_cpu` below NUM_CPUS. Under those conditions the assertions hold even when a tick coincides with an access, because the block orders the tick below bus writes and mode changes. The stimulus issues one access per cycle, drives ticks only in separate cycles, and addresses only the configured timers. This keeps each expected value a simple count of ticks since the last load.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int DATA_W   = 32;
  localparam int SUB_W    = 9;                 // bits below the tick step
  localparam int CTR_W    = 31;                // counter-mode value width
  localparam int USR_W    = 63;                // user-mode value width
  localparam int CPER_W   = CTR_W - SUB_W;     // counter-mode step count
  localparam int UPER_W   = USR_W - SUB_W;     // user-mode step count
  localparam int HI_LSB   = DATA_W - SUB_W;    // step bit carried in upper word
  localparam int MAX_CPUS = 16;
  localparam int CPU_W    = $clog2(MAX_CPUS);
  localparam int WORD_W   = 3;

  typedef enum logic [WORD_W-1:0] {
    REG_LIM_HI = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_SOFTLIM = 3'd2,
    REG_RUN    = 3'd3,
    REG_MODE   = 3'd4
  } reg_word_e;
endpackage

// File: rtl/ctmr_mode.sv
module ctmr_mode
  import ctmr_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [NUM_CPUS-1:0] wr_bits,
  output logic [NUM_CPUS-1:0] mode_q,
  output logic [NUM_CPUS-1:0] enter_user,
  output logic [NUM_CPUS-1:0] leave_user
);
  // Transition pulses are valid in the write cycle and land with the new mode.
  always_comb begin
    enter_user = '0;
    leave_user = '0;
    if (wr_en) begin
      enter_user = wr_bits & ~mode_q;
      leave_user = ~wr_bits & mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_en) mode_q <= wr_bits;
  end
endmodule

// File: rtl/ctmr_unit.sv
module ctmr_unit
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              user_mode,
  input  logic              enter_user,
  input  logic              leave_user,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [1:0]        acc_word,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              running
);
  localparam logic [UPER_W-1:0] USR_TOP = {UPER_W{1'b1}};
  localparam logic [UPER_W-1:0] CTR_TOP = UPER_W'({CPER_W{1'b1}});

  logic [UPER_W-1:0] cnt_q, cnt_inc, lim_eff;
  logic [CPER_W-1:0] lim_q;
  logic              reached_q, irq_q, run_q, wrap;

  always_comb begin
    if (user_mode)        lim_eff = USR_TOP;
    else if (lim_q == '0) lim_eff = CTR_TOP;
    else                  lim_eff = UPER_W'(lim_q);
    cnt_inc = cnt_q + 1'b1;
    wrap    = (cnt_inc >= lim_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      run_q     <= 1'b1;
    end else begin
      // lowest priority: counting
      if (run_q && tick) begin
        if (wrap) begin
          cnt_q     <= '0;
          reached_q <= 1'b1;
          if (!user_mode) irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
      // register writes
      if (acc_wr) begin
        unique case (acc_word)
          2'd0: begin
            if (user_mode) begin
              cnt_q[UPER_W-1:HI_LSB] <= acc_wdata[UPER_W-HI_LSB-1:0];
              reached_q              <= 1'b0;
            end else begin
              lim_q <= acc_wdata[CTR_W-1:SUB_W];
              cnt_q <= '0;
              irq_q <= 1'b0;
            end
          end
          2'd1: begin
            if (user_mode) begin
              cnt_q[HI_LSB-1:0] <= acc_wdata[DATA_W-1:SUB_W];
              reached_q         <= 1'b0;
            end
          end
          2'd2: begin
            if (!user_mode) lim_q <= acc_wdata[CTR_W-1:SUB_W];
          end
          default: begin
            if (user_mode) run_q <= acc_wdata[0];
          end
        endcase
      end
      // counter-mode limit read acknowledges the interrupt
      if (acc_rd && acc_word == 2'd0 && !user_mode) begin
        reached_q <= 1'b0;
        irq_q     <= 1'b0;
      end
      // highest priority: mode transitions
      if (enter_user) begin
        irq_q <= 1'b0;
        run_q <= 1'b0;
        cnt_q <= '0;
      end
      if (leave_user) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        lim_q <= '0;
      end
    end
  end

  always_comb begin
    unique case (acc_word)
      2'd0: rdata = user_mode ? {reached_q, cnt_q[UPER_W-1:HI_LSB]}
                              : {1'b0, lim_q, {SUB_W{1'b0}}};
      2'd1: rdata = user_mode ? {cnt_q[HI_LSB-1:0], {SUB_W{1'b0}}}
                              : {reached_q, cnt_q[CPER_W-1:0], {SUB_W{1'b0}}};
      2'd2: rdata = '0;
      default: rdata = DATA_W'(run_q);
    endcase
  end

  assign irq     = irq_q;
  assign running = run_q;
endmodule

// File: rtl/cpu_timer_bank.sv
module cpu_timer_bank
  import ctmr_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [3:0]          bus_cpu,
  input  logic [2:0]          bus_word,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_CPUS-1:0] irq
);
  logic                mode_hit, unit_word;
  logic [NUM_CPUS-1:0] mode_vec, run_vec, to_user, to_ctr;
  logic [DATA_W-1:0]   unit_rd [NUM_CPUS];

  assign mode_hit  = (bus_word == REG_MODE);
  assign unit_word = (bus_word < REG_MODE);

  ctmr_mode #(.NUM_CPUS(NUM_CPUS)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr && mode_hit),
    .wr_bits    (bus_wdata[NUM_CPUS-1:0]),
    .mode_q     (mode_vec),
    .enter_user (to_user),
    .leave_user (to_ctr)
  );

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_unit
    logic sel;
    assign sel = unit_word && (bus_cpu == CPU_W'(g));
    ctmr_unit u_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .user_mode  (mode_vec[g]),
      .enter_user (to_user[g]),
      .leave_user (to_ctr[g]),
      .acc_wr     (bus_wr && sel),
      .acc_rd     (bus_rd && sel),
      .acc_word   (bus_word[1:0]),
      .acc_wdata  (bus_wdata),
      .rdata      (unit_rd[g]),
      .irq        (irq[g]),
      .running    (run_vec[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (mode_hit) begin
      bus_rdata = DATA_W'(mode_vec);
    end else if (unit_word) begin
      for (int i = 0; i < NUM_CPUS; i++)
        if (bus_cpu == CPU_W'(i)) bus_rdata = unit_rd[i];
    end
  end
endmodule

// File: rtl/cpu_timer_bank_checker.sv
module cpu_timer_bank_checker #(
  parameter int NUM_CPUS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                bus_rd,
  input logic [3:0]          bus_cpu,
  input logic [2:0]          bus_word,
  input logic [31:0]         bus_rdata,
  input logic [NUM_CPUS-1:0] irq,
  input logic [NUM_CPUS-1:0] mode_vec,
  input logic [NUM_CPUS-1:0] run_vec
);
  logic [15:0] irq_pad, mode_pad;
  assign irq_pad  = 16'(irq);
  assign mode_pad = 16'(mode_vec);

  // R12: a timer in user mode never drives its interrupt
  p_user_no_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & mode_vec) == '0);

  // R6: mode readback has nothing above the configured timers
  p_mode_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word == 3'd4) |-> ((bus_rdata >> NUM_CPUS) == '0));

  // R7: entering user mode leaves the timer stopped
  p_enter_user_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_vec & ~$past(mode_vec)) & run_vec) == '0);

  // R8: leaving user mode leaves the timer running
  p_leave_user_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mode_vec & $past(mode_vec)) & ~run_vec) == '0);

  // R2: an interrupt only rises after a tick
  p_irq_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq)) != '0) |-> $past(tick));

  // R3: a counter-mode limit read drops that processor's interrupt
  p_limit_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_word == 3'd0 && 32'(bus_cpu) < NUM_CPUS && !mode_pad[bus_cpu])
      |=> !irq_pad[$past(bus_cpu)]);
endmodule

bind cpu_timer_bank cpu_timer_bank_checker #(.NUM_CPUS(NUM_CPUS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_rd    (bus_rd),
  .bus_cpu   (bus_cpu),
  .bus_word  (bus_word),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .mode_vec  (mode_vec),
  .run_vec   (run_vec)
);

// File: tb/cpu_timer_bank_bench.sv
`timescale 1ns/1ps
module cpu_timer_bank_bench;
  localparam int  NCPU = 4;
  localparam time CLK  = 5ns;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  cpu;
    logic [2:0]  word;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'd0, 3'd0, 32'h0000_0A00, 32'h0, 4'd2},        // R2 limit 5
    '{OP_TK, 4'd0, 3'd0, 32'd3,         32'h0, 4'd2},        // R2
    '{OP_RD, 4'd0, 3'd1, 32'h0,         32'h0000_0600, 4'd2},// R2
    '{OP_TK, 4'd0, 3'd0, 32'd2,         32'h0, 4'd2},        // R2 wrap
    '{OP_RD, 4'd0, 3'd1, 32'h0,         32'h8000_0000, 4'd2},// R2 reached
    '{OP_RD, 4'd0, 3'd0, 32'h0,         32'h0000_0A00, 4'd3},// R3
    '{OP_RD, 4'd0, 3'd1, 32'h0,         32'h0, 4'd3},        // R3 cleared
    '{OP_WR, 4'd0, 3'd1, 32'h1234_5600, 32'h0, 4'd5},        // R5 ignored
    '{OP_RD, 4'd0, 3'd1, 32'h0,         32'h0, 4'd5},        // R5
    '{OP_WR, 4'd0, 3'd3, 32'h0,         32'h0, 4'd5},        // R5 ignored
    '{OP_RD, 4'd0, 3'd3, 32'h0,         32'h1, 4'd5},        // R5
    '{OP_WR, 4'd0, 3'd2, 32'h0000_1400, 32'h0, 4'd4},        // R4 limit 10
    '{OP_TK, 4'd0, 3'd0, 32'd4,         32'h0, 4'd4},        // R4
    '{OP_RD, 4'd0, 3'd1, 32'h0,         32'h0000_0800, 4'd4},// R4
    '{OP_WR, 4'd0, 3'd4, 32'h2,         32'h0, 4'd6},        // R6 cpu1 user
    '{OP_RD, 4'd0, 3'd4, 32'h0,         32'h2, 4'd6},        // R6
    '{OP_RD, 4'd1, 3'd3, 32'h0,         32'h0, 4'd7},        // R7 stopped
    '{OP_TK, 4'd0, 3'd0, 32'd5,         32'h0, 4'd11},       // R11
    '{OP_RD, 4'd1, 3'd1, 32'h0,         32'h0, 4'd11},       // R11 frozen
    '{OP_WR, 4'd1, 3'd3, 32'h1,         32'h0, 4'd11},       // R11 start
    '{OP_TK, 4'd0, 3'd0, 32'd3,         32'h0, 4'd11},       // R11
    '{OP_RD, 4'd1, 3'd1, 32'h0,         32'h0000_0600, 4'd9},// R9
    '{OP_RD, 4'd1, 3'd0, 32'h0,         32'h0, 4'd9},        // R9
    '{OP_WR, 4'd1, 3'd0, 32'h7FFF_FFFF, 32'h0, 4'd10},       // R10
    '{OP_WR, 4'd1, 3'd1, 32'hFFFF_FA00, 32'h0, 4'd10},       // R10
    '{OP_TK, 4'd0, 3'd0, 32'd1,         32'h0, 4'd12},       // R12
    '{OP_RD, 4'd1, 3'd0, 32'h0,         32'h7FFF_FFFF, 4'd10},// R10
    '{OP_RD, 4'd1, 3'd1, 32'h0,         32'hFFFF_FC00, 4'd9},// R9
    '{OP_TK, 4'd0, 3'd0, 32'd1,         32'h0, 4'd12},       // R12 wrap
    '{OP_RD, 4'd1, 3'd0, 32'h0,         32'h8000_0000, 4'd12},// R12
    '{OP_RD, 4'd1, 3'd1, 32'h0,         32'h0, 4'd12},       // R12
    '{OP_WR, 4'd1, 3'd1, 32'h0000_0200, 32'h0, 4'd10},       // R10 clears reached
    '{OP_RD, 4'd1, 3'd0, 32'h0,         32'h0, 4'd10},       // R10
    '{OP_RD, 4'd1, 3'd1, 32'h0,         32'h0000_0200, 4'd10},// R10
    '{OP_WR, 4'd1, 3'd3, 32'h0,         32'h0, 4'd11},       // R11 stop
    '{OP_TK, 4'd0, 3'd0, 32'd4,         32'h0, 4'd11},       // R11
    '{OP_RD, 4'd1, 3'd1, 32'h0,         32'h0000_0200, 4'd11},// R11
    '{OP_WR, 4'd0, 3'd4, 32'h0000_FFFF, 32'h0, 4'd6},        // R6
    '{OP_RD, 4'd0, 3'd4, 32'h0,         32'h0000_000F, 4'd6},// R6 upper held 0
    '{OP_WR, 4'd0, 3'd4, 32'h0,         32'h0, 4'd8},        // R8 all counter
    '{OP_RD, 4'd1, 3'd3, 32'h0,         32'h1, 4'd8},        // R8 running
    '{OP_RD, 4'd1, 3'd0, 32'h0,         32'h0, 4'd8},        // R8 limit 0
    '{OP_TK, 4'd0, 3'd0, 32'd2,         32'h0, 4'd8},        // R8
    '{OP_RD, 4'd1, 3'd1, 32'h0,         32'h0000_0400, 4'd8} // R8 count from 0
  };

  logic            clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]      bus_cpu = '0;
  logic [2:0]      bus_word = '0;
  logic [31:0]     bus_wdata = '0, bus_rdata;
  logic [NCPU-1:0] irq;
  int              n_chk = 0, n_bad = 0;
  bit              done = 1'b0;

  always #(CLK/2) clk = ~clk;

  cpu_timer_bank #(.NUM_CPUS(NCPU)) u_cpu_timer_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_cpu(bus_cpu), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] c, input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_cpu = c; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] c, input logic [2:0] w, input int req,
                    input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_cpu = c; bus_word = w;
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(1, 32'(irq), 32'h0);
    rd(4'd0, 3'd4, 1, 32'h0);
    rd(4'd0, 3'd3, 1, 32'h1);
    rd(4'd0, 3'd1, 1, 32'h0);
    rd(4'd0, 3'd0, 1, 32'h0);

    for (int i = 0; i < NV; i++) begin
      unique case (VECS[i].op)
        OP_WR:   wr(VECS[i].cpu, VECS[i].word, VECS[i].data);
        OP_RD:   rd(VECS[i].cpu, VECS[i].word, int'(VECS[i].req), VECS[i].exp);
        default: ticks(int'(VECS[i].data));
      endcase
    end

    // R2 / R3: interrupt raise and acknowledge on cpu2
    wr(4'd2, 3'd0, 32'h0000_0600);
    ticks(3);
    check(2, 32'(irq[2]), 32'h1);
    rd(4'd2, 3'd0, 3, 32'h0000_0600);
    check(3, 32'(irq[2]), 32'h0);
    // R7: entering user mode drops a pending interrupt
    ticks(3);
    check(2, 32'(irq[2]), 32'h1);
    wr(4'd0, 3'd4, 32'h4);
    check(7, 32'(irq[2]), 32'h0);
    rd(4'd2, 3'd3, 7, 32'h0);
    rd(4'd2, 3'd1, 7, 32'h0);
    // R12: user wrap sets reached with no interrupt
    wr(4'd2, 3'd0, 32'h7FFF_FFFF);
    wr(4'd2, 3'd1, 32'hFFFF_FC00);
    wr(4'd2, 3'd3, 32'h1);
    ticks(1);
    rd(4'd2, 3'd0, 12, 32'h8000_0000);
    check(12, 32'(irq[2]), 32'h0);

    summary();
  end
endmodule